// File: doc/BRIEF.md
# PCIe bridge interrupt status aggregator

This block gathers the interrupt sources of a PCIe-to-AXI bridge into a local status word, lets software enable them through a local mask, and drives one registered interrupt line. Sources include DMA error flags for two engines, translation errors on the AXI side and the PCIe side, the four legacy INTx lines, an AER event, a power-management/hotplug event and a system error.

Incoming MSI writes are represented by a strobe carrying a vector index. Each accepted strobe sets one bit in a per-vector MSI status word and the MSI summary bit in the local status word. A second status/mask pair collects host-side events. A register holds the MSI target address. A read-only configuration word reports the MSI-X capability and the supported vector count.

All registers sit behind a plain 32-bit port with a write strobe and combinational read data. Every status word is write-one-to-clear.

The output stage is a two-state machine:
- State `IRQ_QUIET` moves to `IRQ_RAISED` when any enabled local bit is pending. Otherwise it stays in `IRQ_QUIET`.
- State `IRQ_RAISED` returns to `IRQ_QUIET` once nothing enabled is pending. Otherwise it stays in `IRQ_RAISED`.
- The interrupt output is high exactly in `IRQ_RAISED`.

Top module: `pcie_irq_agg`

## Requirements
- R1: After reset every status, mask and address register reads 0 and `irq_o` is low.
- R2: Local status latches sources one cycle after a pulse on `loc_evt_i`. The latched bits are:
  - 8 and 9: DMA errors for engines 0 and 1.
  - 16 to 18: AXI-side post, fetch and read-timeout errors.
  - 20 to 22: PCIe-side post, fetch and read-timeout errors.
  - 24 to 27: INTA to INTD.
  - 29: AER event.
  - 30: PM/hotplug event.
  - 31: system error.

  All other positions, including input bit 28, are ignored and read 0.
- R3: Writing to local status (0x184), host status (0x18C) or MSI status (0x194) clears each bit written as 1 and leaves bits written as 0 unchanged. Writing all ones clears the whole word.
- R4: When a source sets a status bit in the same cycle as a write-one-to-clear of that bit, the bit stays set.
- R5: An MSI strobe whose index is below the vector count 2^MSI_CNT_LOG2 sets that bit of MSI status and local bit 28 one cycle later. A strobe with a higher index changes nothing.
- R6: `irq_o` is high in the cycle after one where (local status AND local mask) is nonzero, and low in the cycle after one where it is zero.
- R7: Local mask (0x180) is an enable mask and reads back only the implemented bit positions listed in R2 plus bit 28. A mask of 0 keeps `irq_o` low whatever is pending.
- R8: Host status (0x18C) latches `host_evt_i` pulses. Host mask (0x188) is a full 32-bit read/write word.
- R9: The MSI address register (0x190) is a 32-bit read/write word.
- R10: Offset 0xA8 reads the MSI-X capability in bit 31 and MSI_CNT_LOG2 in bits 6:4, with all other bits 0. Writes to 0xA8 are ignored.
- R11: Undefined offsets read 0, and writes to them change no register.
- R12: Writing only bit 24+k to local status clears INTx line k alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_evt_i | input | 32 | Local source pulses at their status bit positions |
| host_evt_i | input | HOST_W | Host-side source pulses |
| msi_stb_i | input | 1 | One received MSI |
| msi_idx_i | input | 5 | Vector index (MSI data) of the strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The bench builds the block with MSI_CNT_LOG2 = 3 and the MSI-X capability set. With 8 vectors, strobes with indices 8 to 31 become reachable, and they must leave both MSI status and the summary bit untouched. The nonzero capability and count field are visible in the configuration readback. Random sparse source pulses, MSI strobes and writes to defined and undefined offsets run alongside directed cases for per-line INTx clearing and for a set colliding with a clear in the same cycle.

// File: rtl/pcie_irq_pkg.sv
package pcie_irq_pkg;

    localparam int REG_AW    = 12;
    localparam int REG_DW    = 32;
    localparam int MSI_IDX_W = 5;
    localparam int SUM_BIT   = 28;

    localparam logic [REG_AW-1:0] OFF_CFG     = 12'h0A8;
    localparam logic [REG_AW-1:0] OFF_LMASK   = 12'h180;
    localparam logic [REG_AW-1:0] OFF_LSTAT   = 12'h184;
    localparam logic [REG_AW-1:0] OFF_HMASK   = 12'h188;
    localparam logic [REG_AW-1:0] OFF_HSTAT   = 12'h18C;
    localparam logic [REG_AW-1:0] OFF_MADDR   = 12'h190;
    localparam logic [REG_AW-1:0] OFF_MSTAT   = 12'h194;

    // implemented local positions: DMA err, AXI err, PCIe err, INTx, summary, AER, PM, SYS
    localparam logic [REG_DW-1:0] LOCAL_IMPL  = 32'hFF77_0300;
    localparam logic [REG_DW-1:0] SUM_MASK    = 32'h1000_0000;

    typedef enum logic [0:0] {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_LMASK,
        SEL_LSTAT,
        SEL_HMASK,
        SEL_HSTAT,
        SEL_MADDR,
        SEL_MSTAT
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [REG_AW-1:0] addr);
        reg_sel_e sel;
        case (addr)
            OFF_CFG:   sel = SEL_CFG;
            OFF_LMASK: sel = SEL_LMASK;
            OFF_LSTAT: sel = SEL_LSTAT;
            OFF_HMASK: sel = SEL_HMASK;
            OFF_HSTAT: sel = SEL_HSTAT;
            OFF_MADDR: sel = SEL_MADDR;
            OFF_MSTAT: sel = SEL_MSTAT;
            default:   sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/pirq_w1c_bank.sv
module pirq_w1c_bank #(
    parameter int               WIDTH = 32,
    parameter logic [WIDTH-1:0] IMPL  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic             clr_we_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] q_o
);

    logic unused_bits;
    assign unused_bits = ^{set_i & ~IMPL, clr_i & ~IMPL};

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (IMPL[i]) begin : g_flop
            logic bit_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else if (set_i[i]) begin
                    bit_q <= 1'b1;          // a new event outranks a clear
                end else if (clr_we_i && clr_i[i]) begin
                    bit_q <= 1'b0;
                end
            end
            assign q_o[i] = bit_q;
        end else begin : g_tie
            assign q_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/pirq_msi_capture.sv
module pirq_msi_capture #(
    parameter int IDX_W    = 5,
    parameter int CNT_LOG2 = 5
) (
    input  logic                  stb_i,
    input  logic [IDX_W-1:0]      idx_i,
    output logic [(1<<IDX_W)-1:0] hit_vec_o,
    output logic                  hit_o
);

    localparam int NUM_VEC = 1 << CNT_LOG2;

    logic in_range;
    assign in_range = stb_i && (int'(idx_i) < NUM_VEC);
    assign hit_o    = in_range;

    for (genvar v = 0; v < (1 << IDX_W); v++) begin : g_vec
        assign hit_vec_o[v] = in_range && (idx_i == IDX_W'(v));
    end

endmodule

// File: rtl/pirq_irq_fsm.sv
module pirq_irq_fsm
    import pcie_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    output logic irq_o
);

    irq_state_e state_q, state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            IRQ_QUIET:  state_n = pend_i ? IRQ_RAISED : IRQ_QUIET;
            IRQ_RAISED: state_n = pend_i ? IRQ_RAISED : IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/pcie_irq_agg.sv
module pcie_irq_agg
    import pcie_irq_pkg::*;
#(
    parameter int MSI_CNT_LOG2 = 5,
    parameter bit MSIX_CAP     = 1'b0,
    parameter int HOST_W       = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_DW-1:0]    loc_evt_i,
    input  logic [HOST_W-1:0]    host_evt_i,
    input  logic                 msi_stb_i,
    input  logic [MSI_IDX_W-1:0] msi_idx_i,
    input  logic                 reg_we_i,
    input  logic [REG_AW-1:0]    reg_addr_i,
    input  logic [REG_DW-1:0]    reg_wdata_i,
    output logic [REG_DW-1:0]    reg_rdata_o,
    output logic                 irq_o
);

    localparam int              NUM_VEC   = 1 << MSI_CNT_LOG2;
    localparam logic [REG_DW-1:0] MSI_VALID = (NUM_VEC >= REG_DW) ? {REG_DW{1'b1}}
                                            : ((REG_DW'(1) << NUM_VEC) - REG_DW'(1));
    localparam logic [REG_DW-1:0] CFG_WORD  = {MSIX_CAP, 24'd0, 3'(MSI_CNT_LOG2), 4'd0};

    reg_sel_e            sel;
    logic [REG_DW-1:0]   lmask_q;
    logic [HOST_W-1:0]   hmask_q;
    logic [REG_DW-1:0]   maddr_q;
    logic [REG_DW-1:0]   lstat_q;
    logic [HOST_W-1:0]   hstat_q;
    logic [REG_DW-1:0]   mstat_q;
    logic [REG_DW-1:0]   msi_hit_vec;
    logic                msi_hit;
    logic [REG_DW-1:0]   lset;
    logic                pend;

    assign sel = decode_offset(reg_addr_i);

    // plain read/write words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lmask_q <= '0;
            hmask_q <= '0;
            maddr_q <= '0;
        end else if (reg_we_i) begin
            if (sel == SEL_LMASK) lmask_q <= reg_wdata_i & LOCAL_IMPL;
            if (sel == SEL_HMASK) hmask_q <= reg_wdata_i[HOST_W-1:0];
            if (sel == SEL_MADDR) maddr_q <= reg_wdata_i;
        end
    end

    pirq_msi_capture #(
        .IDX_W    (MSI_IDX_W),
        .CNT_LOG2 (MSI_CNT_LOG2)
    ) u_msi_cap (
        .stb_i     (msi_stb_i),
        .idx_i     (msi_idx_i),
        .hit_vec_o (msi_hit_vec),
        .hit_o     (msi_hit)
    );

    assign lset = (loc_evt_i & ~SUM_MASK) | (msi_hit ? SUM_MASK : '0);

    pirq_w1c_bank #(
        .WIDTH (REG_DW),
        .IMPL  (LOCAL_IMPL)
    ) u_local_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (lset),
        .clr_we_i (reg_we_i && (sel == SEL_LSTAT)),
        .clr_i    (reg_wdata_i),
        .q_o      (lstat_q)
    );

    pirq_w1c_bank #(
        .WIDTH (HOST_W),
        .IMPL  ({HOST_W{1'b1}})
    ) u_host_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (host_evt_i),
        .clr_we_i (reg_we_i && (sel == SEL_HSTAT)),
        .clr_i    (reg_wdata_i[HOST_W-1:0]),
        .q_o      (hstat_q)
    );

    pirq_w1c_bank #(
        .WIDTH (REG_DW),
        .IMPL  (MSI_VALID)
    ) u_msi_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (msi_hit_vec),
        .clr_we_i (reg_we_i && (sel == SEL_MSTAT)),
        .clr_i    (reg_wdata_i),
        .q_o      (mstat_q)
    );

    assign pend = |(lstat_q & lmask_q);

    pirq_irq_fsm u_irq_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .irq_o  (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        unique case (sel)
            SEL_NONE:  reg_rdata_o = '0;
            SEL_CFG:   reg_rdata_o = CFG_WORD;
            SEL_LMASK: reg_rdata_o = lmask_q;
            SEL_LSTAT: reg_rdata_o = lstat_q;
            SEL_HMASK: reg_rdata_o = REG_DW'(hmask_q);
            SEL_HSTAT: reg_rdata_o = REG_DW'(hstat_q);
            SEL_MADDR: reg_rdata_o = maddr_q;
            SEL_MSTAT: reg_rdata_o = mstat_q;
        endcase
    end

endmodule

// File: rtl/pirq_chk.sv
module pirq_chk
    import pcie_irq_pkg::*;
#(
    parameter int MSI_CNT_LOG2 = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [REG_DW-1:0]    loc_evt,
    input logic                 msi_stb,
    input logic [MSI_IDX_W-1:0] msi_idx,
    input logic                 reg_we,
    input logic [REG_AW-1:0]    reg_addr,
    input logic [REG_DW-1:0]    reg_wdata,
    input logic [REG_DW-1:0]    loc_status,
    input logic [REG_DW-1:0]    loc_mask,
    input logic [REG_DW-1:0]    msi_status,
    input logic                 irq
);

    localparam int NV = 1 << MSI_CNT_LOG2;
    localparam logic [REG_DW-1:0] SRC_BITS = LOCAL_IMPL & ~SUM_MASK;

    assert_irq_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(loc_status & loc_mask)) |=> irq);

    assert_irq_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(loc_status & loc_mask)) |=> !irq);

    assert_src_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(loc_evt & SRC_BITS)) |=>
        ((loc_status & $past(loc_evt & SRC_BITS)) == $past(loc_evt & SRC_BITS)));

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFF_LSTAT && (|(loc_evt & SRC_BITS & reg_wdata))) |=>
        ((loc_status & $past(loc_evt & SRC_BITS & reg_wdata)) != '0));

    assert_msi_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_stb && (int'(msi_idx) < NV)) |=>
        (msi_status[$past(msi_idx)] && loc_status[SUM_BIT]));

    assert_w1c_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFF_LSTAT && !msi_stb && loc_evt == '0) |=>
        ((loc_status & $past(reg_wdata)) == '0));

endmodule

bind pcie_irq_agg pirq_chk #(.MSI_CNT_LOG2(MSI_CNT_LOG2)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .loc_evt    (loc_evt_i),
    .msi_stb    (msi_stb_i),
    .msi_idx    (msi_idx_i),
    .reg_we     (reg_we_i),
    .reg_addr   (reg_addr_i),
    .reg_wdata  (reg_wdata_i),
    .loc_status (lstat_q),
    .loc_mask   (lmask_q),
    .msi_status (mstat_q),
    .irq        (irq_o)
);

// File: tb/pcie_irq_agg_test.sv
module pcie_irq_agg_test;
    import pcie_irq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_LOG2   = 3;
    localparam int NV         = 1 << CNT_LOG2;
    localparam logic [31:0] IMPL_BITS = 32'hFF77_0300;
    localparam logic [31:0] CFG_EXP   = 32'h8000_0030;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] loc_evt = '0;
    logic [31:0] host_evt = '0;
    logic        msi_stb = 1'b0;
    logic [4:0]  msi_idx = '0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcie_irq_agg #(.MSI_CNT_LOG2(CNT_LOG2), .MSIX_CAP(1'b1), .HOST_W(32)) uut (
        .clk (clk), .rst_n (rst_n), .loc_evt_i (loc_evt), .host_evt_i (host_evt),
        .msi_stb_i (msi_stb), .msi_idx_i (msi_idx), .reg_we_i (reg_we),
        .reg_addr_i (reg_addr), .reg_wdata_i (reg_wdata), .reg_rdata_o (reg_rdata),
        .irq_o (irq)
    );

    logic [31:0] m_lstat = '0, m_lmask = '0, m_hstat = '0, m_hmask = '0;
    logic [31:0] m_maddr = '0, m_mstat = '0;
    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a);
        case (a)
            12'h0A8: return CFG_EXP;
            12'h180: return m_lmask;
            12'h184: return m_lstat;
            12'h188: return m_hmask;
            12'h18C: return m_hstat;
            12'h190: return m_maddr;
            12'h194: return m_mstat;
            default: return 32'h0;
        endcase
    endfunction

    // one clock: drive after a falling edge, update the model, check irq at the next falling edge
    task automatic cyc(input logic [31:0] evt, input logic [31:0] hevt, input logic stb,
                       input logic [4:0] idx, input logic we, input logic [11:0] a,
                       input logic [31:0] wd);
        logic exp_irq;
        logic hit;
        logic [31:0] clr_l, clr_h, clr_m;
        loc_evt = evt; host_evt = hevt; msi_stb = stb; msi_idx = idx;
        reg_we = we; reg_addr = a; reg_wdata = wd;
        exp_irq = |(m_lstat & m_lmask);
        hit   = stb && (int'(idx) < NV);
        clr_l = (we && a == 12'h184) ? wd : 32'h0;
        clr_h = (we && a == 12'h18C) ? wd : 32'h0;
        clr_m = (we && a == 12'h194) ? wd : 32'h0;
        m_lstat = (m_lstat & ~clr_l) | (evt & IMPL_BITS & ~32'h1000_0000) | (hit ? 32'h1000_0000 : 32'h0);
        m_hstat = (m_hstat & ~clr_h) | hevt;
        m_mstat = (m_mstat & ~clr_m) | (hit ? (32'h1 << idx) : 32'h0);
        if (we && a == 12'h180) m_lmask = wd & IMPL_BITS;
        if (we && a == 12'h188) m_hmask = wd;
        if (we && a == 12'h190) m_maddr = wd;
        @(negedge clk);
        loc_evt = '0; host_evt = '0; msi_stb = 1'b0; reg_we = 1'b0;
        check("R6 irq", {31'b0, irq}, {31'b0, exp_irq});
    endtask

    task automatic idle();
        cyc('0, '0, 1'b0, '0, 1'b0, 12'h000, '0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cyc('0, '0, 1'b0, '0, 1'b1, a, d);
    endtask

    task automatic readchk(input string tag, input logic [11:0] a);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, model_read(a));
    endtask

    function automatic logic [11:0] pick_addr(input int unsigned k);
        case (k % 9)
            0: return 12'h0A8;
            1: return 12'h180;
            2: return 12'h184;
            3: return 12'h188;
            4: return 12'h18C;
            5: return 12'h190;
            6: return 12'h194;
            7: return 12'h1A0;
            default: return 12'h184;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int k = 1; k < 8; k++) readchk("R1 reset read", pick_addr(k));
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        // R10 configuration word, write ignored
        readchk("R10 cfg", 12'h0A8);
        wr(12'h0A8, 32'hFFFF_FFFF);
        readchk("R10 cfg after write", 12'h0A8);

        // R2 all sources at once, mask still zero (R7)
        cyc(32'hFFFF_FFFF, '0, 1'b0, '0, 1'b0, 12'h000, '0);
        readchk("R2 implemented bits", 12'h184);
        check("R2 value", reg_rdata, 32'hEF77_0300);
        idle();
        check("R7 zero mask keeps irq low", {31'b0, irq}, 32'h0);

        // R7 enable mask readback and irq rise
        wr(12'h180, 32'hFFFF_FFFF);
        readchk("R7 mask readback", 12'h180);
        idle();
        check("R7 irq raised", {31'b0, irq}, 32'h1);

        // R12 clear INTB only
        wr(12'h184, 32'h0200_0000);
        readchk("R12 single INTx clear", 12'h184);

        // R3 clear all, then R4 set colliding with clear
        wr(12'h184, 32'hFFFF_FFFF);
        readchk("R3 clear all", 12'h184);
        cyc(32'h0000_0100, '0, 1'b0, '0, 1'b1, 12'h184, 32'hFFFF_FFFF);
        readchk("R4 set beats clear", 12'h184);
        check("R4 value", reg_rdata, 32'h0000_0100);
        wr(12'h184, 32'h0000_0100);
        idle();
        check("R3 irq drops after clear", {31'b0, irq}, 32'h0);

        // R5 MSI in range and out of range
        cyc('0, '0, 1'b1, 5'd5, 1'b0, 12'h000, '0);
        readchk("R5 vector bit", 12'h194);
        readchk("R5 summary bit", 12'h184);
        wr(12'h184, 32'h1000_0000);
        cyc('0, '0, 1'b1, 5'd20, 1'b0, 12'h000, '0);
        readchk("R5 out-of-range vector", 12'h194);
        readchk("R5 out-of-range summary", 12'h184);
        wr(12'h194, 32'hFFFF_FFFF);
        readchk("R3 MSI clear", 12'h194);

        // R8 host pair
        cyc('0, 32'h0000_00A5, 1'b0, '0, 1'b0, 12'h000, '0);
        readchk("R8 host status", 12'h18C);
        wr(12'h188, 32'h1234_5678);
        readchk("R8 host mask", 12'h188);
        wr(12'h18C, 32'h0000_0005);
        readchk("R8 host clear", 12'h18C);

        // R9 MSI address
        wr(12'h190, 32'hDEAD_BEE0);
        readchk("R9 address", 12'h190);

        // R11 undefined offsets
        wr(12'h1A0, 32'hFFFF_FFFF);
        readchk("R11 undefined read", 12'h1A0);
        readchk("R11 mask untouched", 12'h180);
        readchk("R11 status untouched", 12'h184);

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [31:0] ev, hv, wd;
            logic st, we;
            logic [4:0] ix;
            logic [11:0] a;
            ev = $urandom & $urandom & $urandom & $urandom;
            hv = $urandom & $urandom & $urandom;
            st = ($urandom % 4) == 0;
            ix = 5'($urandom);
            we = ($urandom % 3) == 0;
            a  = pick_addr($urandom);
            wd = (($urandom % 4) == 0) ? 32'hFFFF_FFFF : $urandom;
            cyc(ev, hv, st, ix, we, a, wd);
            readchk("R2 R3 R4 R5 R8 random read", pick_addr($urandom));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule